// File: doc/BRIEF.md
# Asymmetric-Width Byte FIFO

This block is a single-clock first-in first-out buffer whose storage is an array of bytes, not of words. The producer side pushes a fixed number of bytes per accepted write and the consumer side pops a fixed number of bytes per accepted read. The two counts are set independently by parameters, so a 24-bit producer can feed a 16-bit consumer, or a 64-bit producer can feed an 8-bit consumer, over the same byte store.

Both pointers carry one wrap bit above the byte address, so the number of bytes held is their difference. A push is taken only when enough free bytes remain for a whole write word. A pop is taken only when enough bytes are held for a whole read word. A request that cannot be taken changes nothing. Read data is registered. The oldest bytes land in the lowest lanes of the read word.

Top module: `bytefifo_asym`

## Requirements
- R1: While `rst` is high at a rising edge, both pointers and `rd_data` clear. After that edge, `level` is 0, `empty` is 1, `full` is 0 and `rd_data` is 0. This holds both at start-up and when `rst` is raised in the middle of traffic.
- R2: On an accepted write, byte lane i of `wr_data` (bits 8*i+7 down to 8*i, for i from 0 to WR_BITS/8-1) is stored at the next free byte position in arrival order. The bytes therefore leave the FIFO with lane 0 first.
- R3: A write is accepted only when the free space (2^AW minus `level`) is at least WR_BITS/8. `full` is 1 exactly when the free space is below WR_BITS/8. A write request while `full` is 1 leaves the stored bytes and `level` untouched.
- R4: A read is accepted only when `level` is at least RD_BITS/8. `empty` is 1 exactly when `level` is below RD_BITS/8. A read request while `empty` is 1 leaves `rd_data` and `level` untouched.
- R5: After each edge, `level` equals its previous value, plus WR_BITS/8 if a write was accepted, minus RD_BITS/8 if a read was accepted. `level` never exceeds 2^AW.
- R6: On an accepted read, lane i of `rd_data` holds the i-th oldest byte, for i from 0 to RD_BITS/8-1. This value appears after the same rising edge, one cycle after `rd_en` is sampled. `rd_data` holds its value in any cycle with no accepted read.
- R7: A write and a read may both be accepted at the same edge. Acceptance of each is decided from the state before that edge, so a read never consumes bytes written at that same edge.
- R8: Byte positions wrap modulo 2^AW. The port byte counts need not divide the depth, so a single write or read word may straddle the wrap point without loss or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_BITS | Write word, lane 0 oldest |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_BITS | Registered read word, lane 0 oldest |
| full | output | 1 | Fewer than WR_BITS/8 free bytes |
| empty | output | 1 | Fewer than RD_BITS/8 bytes held |
| level | output | AW+1 | Bytes currently held |

## Verification
The bench builds the block with a 24-bit write port, a 16-bit read port and an 8-byte store. Three does not divide eight, so write words start at every byte offset and regularly straddle the wrap point. Each possible occupancy value from 0 to 8 is visited many times, and every combination of write and read request is driven from each of them. Every popped word is compared with a byte-queue model kept in the bench. Fill-to-full and drain-to-empty phases, biased traffic and a reset in the middle of traffic cover the rejection and reset corners.

// File: rtl/bytefifo_asym.sv
module bytefifo_asym #(
  parameter int WR_BITS = 32,
  parameter int RD_BITS = 16,
  parameter int AW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WR_BITS-1:0] wr_data,
  input  logic               rd_en,
  output logic [RD_BITS-1:0] rd_data,
  output logic               full,
  output logic               empty,
  output logic [AW:0]        level
);
  localparam int WB    = WR_BITS / 8;
  localparam int RB    = RD_BITS / 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] WSTEP = (AW+1)'(WB);
  localparam logic [AW:0] RSTEP = (AW+1)'(RB);
  localparam logic [AW:0] CAP   = (AW+1)'(DEPTH);

  if (WR_BITS % 8 != 0 || RD_BITS % 8 != 0 || WB < 1 || RB < 1 ||
      DEPTH < WB || DEPTH < RB) begin : g_bad_cfg
    $error("bytefifo_asym: widths must be whole bytes and fit the store");
  end

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wptr, rptr;
  logic [AW:0] space;
  logic        wr_go, rd_go;

  assign level = wptr - rptr;
  assign space = CAP - level;
  assign full  = space < WSTEP;
  assign empty = level < RSTEP;
  assign wr_go = wr_en & ~full;
  assign rd_go = rd_en & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_go) wptr <= wptr + WSTEP;
      if (rd_go) rptr <= rptr + RSTEP;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int i = 0; i < WB; i++)
        mem[wptr[AW-1:0] + AW'(i)] <= wr_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_go)
      for (int i = 0; i < RB; i++)
        rd_data[8*i +: 8] <= mem[rptr[AW-1:0] + AW'(i)];
  end
endmodule

// File: rtl/bytefifo_asym_chk.sv
module bytefifo_asym_chk #(
  parameter int WR_BITS = 32,
  parameter int RD_BITS = 16,
  parameter int AW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [RD_BITS-1:0] rd_data,
  input logic               full,
  input logic               empty,
  input logic [AW:0]        level
);
  localparam logic [AW:0] WSTEP = (AW+1)'(WR_BITS / 8);
  localparam logic [AW:0] RSTEP = (AW+1)'(RD_BITS / 8);
  localparam logic [AW:0] CAP   = (AW+1)'(1 << AW);

  logic wacc, racc;
  assign wacc = wr_en && !full;
  assign racc = rd_en && !empty;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> level == '0 && empty && !full && rd_data == '0); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) wr_en && full && !racc |=> $stable(level)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en && empty |=> $stable(rd_data)); // R4
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst) !rst |=> level == $past(level) + ($past(wacc) ? WSTEP : '0) - ($past(racc) ? RSTEP : '0)); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) level <= CAP); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !racc |=> $stable(rd_data)); // R6
  AST_BOTH_SIDES: assert property (@(posedge clk) disable iff (rst) wacc && racc |=> level == $past(level) + WSTEP - RSTEP); // R7
endmodule

bind bytefifo_asym bytefifo_asym_chk #(.WR_BITS(WR_BITS), .RD_BITS(RD_BITS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .full(full), .empty(empty), .level(level)
);

// File: tb/bytefifo_asym_tb.sv
`timescale 1ns/1ps
module bytefifo_asym_tb_top;
  localparam int WR_BITS = 24;
  localparam int RD_BITS = 16;
  localparam int AW      = 3;
  localparam int WB = WR_BITS / 8;
  localparam int RB = RD_BITS / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WR_BITS-1:0] wr_data = '0;
  logic [RD_BITS-1:0] rd_data;
  logic full, empty;
  logic [AW:0] level;

  always #4 clk = ~clk;

  bytefifo_asym #(.WR_BITS(WR_BITS), .RD_BITS(RD_BITS), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .level(level));

  int n_chk = 0, n_fail = 0;
  logic [7:0] q[$];
  logic [RD_BITS-1:0] exp_rd = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check(level == q.size(), {tag, " R5 level"}, level, q.size());
    check(full == ((DEPTH - q.size()) < WB), {tag, " R3 full"}, full, (DEPTH - q.size()) < WB);
    check(empty == (q.size() < RB), {tag, " R4 empty"}, empty, q.size() < RB);
    check(rd_data == exp_rd, {tag, " R6 rd_data"}, rd_data, exp_rd);
  endtask

  // one cycle: drive at negedge, edge, check at next negedge
  task automatic step(input bit we, input bit re, input string tag);
    bit wa, ra;
    logic [WR_BITS-1:0] d;
    d = WR_BITS'($urandom);
    wa = we && (DEPTH - q.size()) >= WB;
    ra = re && q.size() >= RB;
    wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    if (ra) for (int i = 0; i < RB; i++) exp_rd[8*i +: 8] = q.pop_front();
    if (wa) for (int i = 0; i < WB; i++) q.push_back(d[8*i +: 8]);
    check_flags(tag);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    q.delete(); exp_rd = '0;
    check(level == 0 && empty && !full && rd_data == '0, {tag, " R1 reset state"},
          {level, empty, full, rd_data}, {4'd0, 1'b1, 1'b0, 16'd0});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("start");
    // fill past full: rejected writes (R3), lane order (R2)
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, "fill R2 R3");
    // drain past empty: rejected reads (R4)
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, "drain R2 R4");
    // every request pair from every reachable level (R7, R8)
    for (int rep = 0; rep < 40; rep++)
      for (int c = 0; c < 4; c++) step(c[0], c[1], "combo R7 R8");
    // biased traffic: write heavy, read heavy, balanced
    for (int ph = 0; ph < 3; ph++)
      for (int k = 0; k < 1500; k++) begin
        int r = $urandom % 8;
        step(ph == 0 ? r < 6 : ph == 1 ? r < 2 : r < 4,
             ph == 0 ? r > 4 : ph == 1 ? r > 1 : r > 3, "mix R2 R6 R8");
      end
    // reset in the middle of traffic (R1)
    step(1'b1, 1'b0, "pre-reset");
    step(1'b1, 1'b1, "pre-reset");
    do_reset("midrun");
    step(1'b0, 1'b1, "post-reset R4");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, "post-reset R7");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule